// File: doc/BRIEF.md
# Multiplexed Expansion Bus Sequencer

This block runs a multiplexed expansion bus. The low address byte and the data share one set of lines. It is clocked by a phase clock at eight times the bus rate, so each bus cycle is eight phase-clock periods long, numbered phase 0 to phase 7. From that phase count the block produces the bus clock E and the address strobe AS. It also drives the shared address/data lanes with a separate output enable, drives the upper address byte, and drives the read/write line.

A requester hands over one transaction at a time through a valid/ready handshake. A transaction carries an address, a direction and write data. A read returns the byte captured on the shared lanes when E falls. A write reports completion once its data hold phase has ended. When no request is waiting, the block keeps running idle bus cycles: E keeps toggling and the other signals stay quiet.

Top module: `mxbus_seq`

## Requirements
- R1: `bus_e` is low during phases 0 to 3 and high during phases 4 to 7 of every bus cycle, so it rises four phase clocks after each fall.
- R2: In a transaction cycle `bus_as` is high in exactly phases 1 and 2. It rises one phase after E falls, stays high for two phases, and E rises one phase after it falls.
- R3: During phases 1 to 3 of a transaction cycle `bus_ad_oe` is 1 and `bus_ad_out` carries the low address byte, so the address is still held for one phase after AS falls.
- R4: `bus_rw` is 0 for a write and 1 for a read. It takes its value on entering phase 1 and holds it through phase 0 of the next cycle.
- R5: `bus_addr_hi` carries the upper address byte. It changes only on entering phase 1 and therefore stays valid through phase 0 of the next cycle.
- R6: In a write, the shared lanes are released in phase 4. The write data is driven in phases 5, 6 and 7 and held through phase 0 of the next cycle.
- R7: In a read, the shared lanes are released from phase 4 to phase 7. `bus_ad_in` is sampled at the clock edge where E falls, and `rsp_done` pulses for one clock in the following phase 0 with that byte on `rsp_rdata`.
- R8: A write raises `rsp_done` for one clock in phase 1 of the next cycle, after its data hold phase.
- R9: In an idle cycle AS stays low, `bus_rw` is 1, the shared lanes are released and E keeps toggling.
- R10: `req_ready` is high only in phase 0, and a request is taken at the edge that ends phase 0. A new cycle may follow a write directly, with its address phases right after the write's hold phase.
- R11: After reset the sequencer is in phase 0 with E low, AS low, `bus_rw` high, the lanes released and `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, eight per bus cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Request taken this clock (phase 0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transaction address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done of a read |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | Read/write line, 1 = read |
| bus_ad_out | output | DATA_W | Shared address/data lanes, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared lanes |
| bus_ad_in | input | DATA_W | Shared address/data lanes, received value |
| bus_addr_hi | output | ADDR_W-DATA_W | Upper address byte |

## Verification
The bench builds the block with its default 16-bit address and 8-bit shared lanes, so the upper address is one byte wide. All-zero, all-ones and single-set-bit patterns can then reach both halves of the address and the data. The bench models the bus so that the read byte sits on the lanes only while E is high. A sampling edge that is one phase late therefore returns the inverted byte. A write that is chained directly into a read brings the hold phase and the next address phase right next to each other.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
    localparam int PH_W = 3;
    localparam logic [PH_W-1:0] PH_LAUNCH    = 3'd0;
    localparam logic [PH_W-1:0] PH_AS_RISE   = 3'd1;
    localparam logic [PH_W-1:0] PH_AS_LAST   = 3'd2;
    localparam logic [PH_W-1:0] PH_ADDR_LAST = 3'd3;
    localparam logic [PH_W-1:0] PH_E_RISE    = 3'd4;
    localparam logic [PH_W-1:0] PH_WD_FIRST  = 3'd5;
    localparam logic [PH_W-1:0] PH_SAMPLE    = 3'd7;
endpackage

// File: rtl/mxbus_phase.sv
module mxbus_phase
    import mxbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_nx
);
    logic [PH_W-1:0] phase_d;

    always_comb begin
        phase_d  = phase_q + PH_W'(1);
        phase_nx = phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LAUNCH;
        else        phase_q <= phase_d;
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_q) == PH_SAMPLE) |-> (phase_q == PH_LAUNCH)); // R1
endmodule

// File: rtl/mxbus_xact.sv
module mxbus_xact
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_q,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              nx_active,
    output logic              nx_write,
    output logic [ADDR_W-1:0] nx_addr,
    output logic [DATA_W-1:0] nx_wdata,
    output logic              cur_active,
    output logic              cur_write
);
    typedef struct packed {
        logic              active;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    xact_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        req_ready = (phase_q == PH_LAUNCH);
        if (req_ready) begin
            x_d.active = req_valid;
            if (req_valid) begin
                x_d.write = req_write;
                x_d.addr  = req_addr;
                x_d.wdata = req_wdata;
            end
        end
        nx_active  = x_d.active;
        nx_write   = x_d.write;
        nx_addr    = x_d.addr;
        nx_wdata   = x_d.wdata;
        cur_active = x_q.active;
        cur_write  = x_q.write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    AST_ACCEPT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.active != $past(x_q.active)) |-> ($past(phase_q) == PH_LAUNCH)); // R10
endmodule

// File: rtl/mxbus_pins.sv
module mxbus_pins
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_q,
    input  logic [PH_W-1:0]   phase_nx,
    input  logic              nx_active,
    input  logic              nx_write,
    input  logic [ADDR_W-1:0] nx_addr,
    input  logic [DATA_W-1:0] nx_wdata,
    output logic              bus_e,
    output logic              bus_as,
    output logic              bus_rw,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [HI_W-1:0]   bus_addr_hi
);
    typedef struct packed {
        logic              e;
        logic              as_;
        logic              rw;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] ad;
        logic              oe;
    } pin_t;

    pin_t p_d, p_q;
    logic addr_win, data_win;

    always_comb begin
        p_d      = p_q;
        addr_win = (phase_nx >= PH_AS_RISE) && (phase_nx <= PH_ADDR_LAST);
        data_win = (phase_nx >= PH_WD_FIRST) || (phase_nx == PH_LAUNCH);

        p_d.e   = (phase_nx >= PH_E_RISE);
        p_d.as_ = nx_active && (phase_nx >= PH_AS_RISE) && (phase_nx <= PH_AS_LAST);

        if (phase_nx == PH_AS_RISE) begin
            p_d.rw = !(nx_active && nx_write);
            if (nx_active) p_d.hi = nx_addr[ADDR_W-1:DATA_W];
        end

        p_d.oe = 1'b0;
        if (nx_active && addr_win) begin
            p_d.oe = 1'b1;
            p_d.ad = nx_addr[DATA_W-1:0];
        end else if (nx_active && nx_write && data_win) begin
            p_d.oe = 1'b1;
            p_d.ad = nx_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q    <= '0;
            p_q.rw <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign bus_e       = p_q.e;
    assign bus_as      = p_q.as_;
    assign bus_rw      = p_q.rw;
    assign bus_ad_out  = p_q.ad;
    assign bus_ad_oe   = p_q.oe;
    assign bus_addr_hi = p_q.hi;

    AST_E_EDGE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_e != $past(bus_e)) |-> (phase_q == PH_LAUNCH || phase_q == PH_E_RISE)); // R1
    AST_AS_IN_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> (!bus_e && !$past(bus_e))); // R2
    AST_AS_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> $past(bus_as, 2)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> (bus_ad_oe && $stable(bus_ad_out))); // R3
    AST_RW_PHASE1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rw != $past(bus_rw)) |-> (phase_q == PH_AS_RISE)); // R4
    AST_HI_PHASE1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_hi != $past(bus_addr_hi)) |-> (phase_q == PH_AS_RISE)); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_E_RISE) |-> !bus_ad_oe); // R6
endmodule

// File: rtl/mxbus_resp.sv
module mxbus_resp
    import mxbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_q,
    input  logic              cur_active,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (cur_active && !cur_write && phase_q == PH_SAMPLE) begin
            r_d.done  = 1'b1;
            r_d.rdata = ad_in;
        end
        if (cur_active && cur_write && phase_q == PH_LAUNCH) begin
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R7
    AST_DONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (phase_q == PH_LAUNCH || phase_q == PH_AS_RISE)); // R8
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_e,
    output logic              bus_as,
    output logic              bus_rw,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [HI_W-1:0]   bus_addr_hi
);
    logic [PH_W-1:0]   phase_q, phase_nx;
    logic              nx_active, nx_write, cur_active, cur_write;
    logic [ADDR_W-1:0] nx_addr;
    logic [DATA_W-1:0] nx_wdata;

    mxbus_phase u_phase (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_nx(phase_nx)
    );

    mxbus_xact #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xact (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .nx_active(nx_active), .nx_write(nx_write),
        .nx_addr(nx_addr), .nx_wdata(nx_wdata),
        .cur_active(cur_active), .cur_write(cur_write)
    );

    mxbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_nx(phase_nx),
        .nx_active(nx_active), .nx_write(nx_write),
        .nx_addr(nx_addr), .nx_wdata(nx_wdata),
        .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_addr_hi(bus_addr_hi)
    );

    mxbus_resp #(.DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q),
        .cur_active(cur_active), .cur_write(cur_write), .ad_in(bus_ad_in),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_as && !bus_e)); // R10
endmodule

// File: tb/test_mxbus_seq.sv
module test_mxbus_seq;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, bus_e, bus_as, bus_rw, bus_ad_oe;
    logic [DW-1:0] rsp_rdata, bus_ad_out;
    logic [DW-1:0] bus_ad_in = '0;
    logic [DW-1:0] rd_val = '0;
    logic [AW-DW-1:0] bus_addr_hi;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mxbus_seq #(.ADDR_W(AW), .DATA_W(DW)) i_mxbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_e(bus_e), .bus_as(bus_as),
        .bus_rw(bus_rw), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi)
    );

    // bus model: read byte present only while E is high
    always @(negedge clk) bus_ad_in = bus_e ? rd_val : ~rd_val;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {write, addr, wdata, read value}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 16'h1234, 8'h00, 8'hA5},
        {1'b1, 16'hBEEF, 8'h3C, 8'h00},
        {1'b0, 16'hFF00, 8'h00, 8'h00},
        {1'b1, 16'h00FF, 8'hFF, 8'h00},
        {1'b0, 16'h8001, 8'h00, 8'hFF},
        {1'b1, 16'h7FFE, 8'h81, 8'h00}
    };

    task automatic wait_launch();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic run_xact(input logic w, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rv);
        wait_launch();
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd; rd_val = rv;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            case (k)
                1: begin
                    chk("R2 as phase1", bus_as, 1);
                    chk("R1 e phase1", bus_e, 0);
                    chk("R3 addr phase1", {bus_ad_oe, bus_ad_out}, {1'b1, a[DW-1:0]});
                    chk("R4 rw", bus_rw, !w);
                    chk("R5 addr_hi", bus_addr_hi, a[AW-1:DW]);
                end
                2: chk("R2 as phase2", bus_as, 1);
                3: begin
                    chk("R2 as phase3", bus_as, 0);
                    chk("R3 addr hold", {bus_ad_oe, bus_ad_out}, {1'b1, a[DW-1:0]});
                end
                4: begin
                    chk("R1 e phase4", bus_e, 1);
                    chk("R6 R7 released phase4", bus_ad_oe, 0);
                end
                5, 6, 7: begin
                    if (w) chk("R6 wdata", {bus_ad_oe, bus_ad_out}, {1'b1, wd});
                    else   chk("R7 released", bus_ad_oe, 0);
                    chk("R7 no early done", rsp_done, 0);
                end
                8: begin
                    chk("R1 e phase0", bus_e, 0);
                    chk("R4 rw hold", bus_rw, !w);
                    chk("R5 hi hold", bus_addr_hi, a[AW-1:DW]);
                    if (w) begin
                        chk("R6 wdata hold", {bus_ad_oe, bus_ad_out}, {1'b1, wd});
                        chk("R8 no done in hold", rsp_done, 0);
                    end else begin
                        chk("R7 read done", {rsp_done, rsp_rdata}, {1'b1, rv});
                    end
                end
                default: begin
                    chk("R8 done phase1", rsp_done, w);
                    chk("R9 idle as", bus_as, 0);
                    chk("R9 idle rw", bus_rw, 1);
                    chk("R9 idle released", bus_ad_oe, 0);
                end
            endcase
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rises, readies;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 e", bus_e, 0);
        chk("R11 as", bus_as, 0);
        chk("R11 rw", bus_rw, 1);
        chk("R11 oe", bus_ad_oe, 0);
        chk("R11 done", rsp_done, 0);
        rst_n = 1'b1;
        chk("R11 phase0 ready", req_ready, 1);

        // R9 R10 idle cycles
        rises = 0; readies = 0;
        for (int i = 0; i < 16; i++) begin
            logic pe;
            pe = bus_e;
            @(negedge clk);
            if (!pe && bus_e) rises++;
            if (req_ready) readies++;
            if (bus_as || !bus_rw || bus_ad_oe) chk("R9 idle quiet", {bus_as, bus_rw, bus_ad_oe}, 3'b010);
        end
        chk("R1 R9 e toggles idle", rises, 2);
        chk("R10 ready once per cycle", readies, 2);

        foreach (VEC[i]) run_xact(VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

        // R10 write chained directly into read
        wait_launch();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hA55A; req_wdata = 8'h69;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (7) @(negedge clk);
        chk("R10 ready at hold", req_ready, 1);
        chk("R6 hold before chain", {bus_ad_oe, bus_ad_out}, {1'b1, 8'h69});
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0C3C; rd_val = 8'h96;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 chained write done", rsp_done, 1);
        chk("R10 chained as", bus_as, 1);
        chk("R10 chained addr", {bus_ad_oe, bus_ad_out}, {1'b1, 8'h3C});
        chk("R4 chained rw", bus_rw, 1);
        chk("R5 chained hi", bus_addr_hi, 8'h0C);
        repeat (7) @(negedge clk);
        chk("R7 chained read", {rsp_done, rsp_rdata}, {1'b1, 8'h96});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule